// File: doc/BRIEF.md
# Data-Ready Polling Serial Reader

This block is the host side of a synchronous serial link to a converter that holds its results in addressed internal registers. It is the serial clock master. A start pulse makes it run one configuration transaction. Chip select goes low. The block sends a write instruction for the three-byte control register, then the 24-bit configuration word, and releases chip select.

After that it loops. It waits for the converter's active-low data-ready line, sends a read instruction for the three-byte data register and clocks in the result. Each received byte goes out through a byte-wide write port with an address that rises by one per byte. After each conversion the block compares the byte count with the programmed buffer length. It either returns to polling or ends the run with a one-cycle done pulse.

The buffer write port is a valid/ready stream. When a byte is received, `wr_valid` rises with `wr_addr` and `wr_data`. These three signals hold steady until a cycle in which `wr_ready` is high. During that wait the serial clock stops at its low level and chip select stays asserted, so the transaction resumes without losing bits. `wr_ready` may stay low for any number of cycles.

Top module: `drdy_burst_reader`

## Requirements
- R1: The first transaction of each run sends the instruction byte 0xC6, then `cfg_word[23:16]`, `cfg_word[15:8]` and `cfg_word[7:0]`, all inside one chip-select-low window. The instruction fields are: bit 7 = 1 (write), bits 6:5 = 2 (three bytes), bit 4 = 0, bits 3:2 = 01 (control register), bits 1:0 = 2 (starting byte).
- R2: After configuration, no read transaction begins while `drdy_n` is high. `cs_n` stays high for as long as `drdy_n` stays high.
- R3: Each read transaction sends the instruction 0x42, which is the same layout with bit 7 = 0 and bits 3:2 = 00 (data register). It then clocks in exactly three bytes. Every chip-select-low window holds exactly 32 rising SCLK edges.
- R4: Received bytes are written in arrival order, first byte first, at addresses 0, 1, 2 and onward from the start of the run.
- R5: After a read, if the number of bytes written is at least `buf_len`, `done` pulses high for exactly one cycle and `busy` falls. Otherwise polling resumes.
- R6: Each SCLK high phase and each SCLK low phase inside a transaction lasts at least HALF_DIV system clocks. HALF_DIV is ceil(CLK_HZ / (2 * MAX_BPS)), which gives 20 at 200 MHz and 5 Mbit/s.
- R7: Data bits are shifted MSB first. MOSI changes only while SCLK is low. MISO is sampled at the SCLK rising edge.
- R8: `sclk` is low whenever `cs_n` is high. Between transactions `cs_n` stays high for at least CS_GAP system clocks.
- R9: A start pulse that arrives while `busy` is high is ignored. It causes no extra configuration transaction and does not change the byte count.
- R10: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_data` and `sclk` all hold their values.
- R11: After reset, `cs_n` = 1, `sclk` = 0, `busy` = 0, `done` = 0 and `wr_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle |
| cfg_word | input | 24 | Control register value, captured at start |
| buf_len | input | ADDR_W | Number of bytes to fill, captured at start |
| busy | output | 1 | High from an accepted start until done |
| done | output | 1 | One-cycle pulse when the buffer has filled |
| wr_valid | output | 1 | Buffer write request |
| wr_ready | input | 1 | Buffer accepts the write this cycle |
| wr_addr | output | ADDR_W | Buffer byte address |
| wr_data | output | 8 | Received byte |
| drdy_n | input | 1 | Converter result ready, active low, asynchronous |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to converter |
| miso | input | 1 | Serial data from converter |

## Verification
The critical coincidence is a received byte being presented on the write port at the moment the bit engine would otherwise move on to the next serial byte. Back-pressure from the buffer and progress on the serial link then compete in the same cycle. The bench drives `wr_ready` from a pseudo-random sequence during one run, so stalls land on every byte position, including the last byte before chip select is released. A converter model records every bit it receives and returns known 24-bit patterns. Every byte and address is checked against a queue that the model fills, and every chip-select window is checked for its edge count while the clock is paused.

// File: rtl/rdr_pkg.sv
`timescale 1ns/1ps
package rdr_pkg;

  localparam int unsigned RDR_WORD_W = 24;
  localparam int unsigned RDR_BYTES  = RDR_WORD_W / 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_WAIT,
    S_PUSH,
    S_GAP,
    S_POLL
  } rdr_state_t;

  // Instruction byte: [7] write, [6:5] byte count - 1, [4] scale select,
  // [3:2] register select, [1:0] first byte index
  function automatic logic [7:0] rdr_instr(input logic wr, input int unsigned nbytes,
                                           input logic [1:0] regsel, input logic [1:0] first);
    logic [1:0] cnt;
    cnt = 2'(nbytes - 1);
    return {wr, cnt, 1'b0, regsel, first};
  endfunction

  localparam logic [7:0] INSTR_CFG = rdr_instr(1'b1, RDR_BYTES, 2'b01, 2'(RDR_BYTES - 1));
  localparam logic [7:0] INSTR_RD  = rdr_instr(1'b0, RDR_BYTES, 2'b00, 2'(RDR_BYTES - 1));

endpackage

// File: rtl/rdr_sync.sv
`timescale 1ns/1ps
module rdr_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= INIT;
    else        chain[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= INIT;
        else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rdr_shift_engine.sv
`timescale 1ns/1ps
module rdr_shift_engine #(
  parameter int unsigned HALF = 20,
  parameter int unsigned W    = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] tx_byte,
  input  logic         miso,
  output logic         sclk,
  output logic         mosi,
  output logic         byte_done,
  output logic [W-1:0] rx_byte
);
  localparam int unsigned CW = $clog2(HALF) + 1;
  localparam int unsigned BW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(W - 1);

  logic          active;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bit_idx;
  logic [W-1:0]  tx_sh;
  logic [W-1:0]  rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      sclk      <= 1'b0;
      cnt       <= '0;
      bit_idx   <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!active) begin
        if (go) begin
          active  <= 1'b1;
          tx_sh   <= tx_byte;
          cnt     <= '0;
          bit_idx <= '0;
        end
      end else if (cnt == CNT_LAST) begin
        cnt <= '0;
        if (!sclk) begin
          sclk  <= 1'b1;
          rx_sh <= {rx_sh[W-2:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_idx == BIT_LAST) begin
            active    <= 1'b0;
            byte_done <= 1'b1;
          end else begin
            bit_idx <= bit_idx + 1'b1;
            tx_sh   <= {tx_sh[W-2:0], 1'b0};
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign mosi    = tx_sh[W-1];
  assign rx_byte = rx_sh;
endmodule

// File: rtl/rdr_sequencer.sv
`timescale 1ns/1ps
module rdr_sequencer
  import rdr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned GAP    = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [RDR_WORD_W-1:0] cfg_word,
  input  logic [ADDR_W-1:0]     buf_len,
  input  logic                  drdy_ok,
  input  logic                  eng_done,
  input  logic [7:0]            rx_byte,
  input  logic                  wr_ready,
  output logic                  go,
  output logic [7:0]            tx_byte,
  output logic                  cs_n,
  output logic                  wr_valid,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [7:0]            wr_data,
  output logic                  busy,
  output logic                  done
);
  localparam int unsigned BCW = $clog2(RDR_BYTES + 1);
  localparam int unsigned GW  = $clog2(GAP + 1);
  localparam logic [BCW-1:0] B_LAST   = BCW'(RDR_BYTES);
  localparam logic [GW-1:0]  GAP_LAST = GW'(GAP - 1);

  rdr_state_t            st;
  logic [BCW-1:0]        bcnt;
  logic                  is_cfg;
  logic [RDR_WORD_W-1:0] cfg_q;
  logic [ADDR_W-1:0]     len_q;
  logic [ADDR_W:0]       ptr;
  logic [GW-1:0]         gap_cnt;

  always_comb begin
    if (bcnt == '0)  tx_byte = is_cfg ? INSTR_CFG : INSTR_RD;
    else if (is_cfg) tx_byte = 8'(cfg_q >> (8 * (RDR_BYTES - int'(bcnt))));
    else             tx_byte = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bcnt     <= '0;
      is_cfg   <= 1'b0;
      cfg_q    <= '0;
      len_q    <= '0;
      ptr      <= '0;
      gap_cnt  <= '0;
      go       <= 1'b0;
      cs_n     <= 1'b1;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      done     <= 1'b0;
    end else begin
      go   <= 1'b0;
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cfg_q  <= cfg_word;
          len_q  <= buf_len;
          ptr    <= '0;
          is_cfg <= 1'b1;
          bcnt   <= '0;
          cs_n   <= 1'b0;
          st     <= S_LOAD;
        end
        S_LOAD: begin
          go <= 1'b1;
          st <= S_WAIT;
        end
        S_WAIT: if (eng_done) begin
          if (!is_cfg && bcnt != '0) begin
            wr_valid <= 1'b1;
            wr_data  <= rx_byte;
            wr_addr  <= ptr[ADDR_W-1:0];
            st       <= S_PUSH;
          end else if (bcnt == B_LAST) begin
            cs_n    <= 1'b1;
            gap_cnt <= '0;
            st      <= S_GAP;
          end else begin
            bcnt <= bcnt + 1'b1;
            st   <= S_LOAD;
          end
        end
        S_PUSH: if (wr_ready) begin
          wr_valid <= 1'b0;
          ptr      <= ptr + 1'b1;
          if (bcnt == B_LAST) begin
            cs_n    <= 1'b1;
            gap_cnt <= '0;
            st      <= S_GAP;
          end else begin
            bcnt <= bcnt + 1'b1;
            st   <= S_LOAD;
          end
        end
        S_GAP: begin
          if (gap_cnt == GAP_LAST) begin
            if (is_cfg) begin
              is_cfg <= 1'b0;
              st     <= S_POLL;
            end else if (ptr >= {1'b0, len_q}) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              st <= S_POLL;
            end
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        S_POLL: if (drdy_ok) begin
          cs_n <= 1'b0;
          bcnt <= '0;
          st   <= S_LOAD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy = (st != S_IDLE);
endmodule

// File: rtl/drdy_burst_reader.sv
`timescale 1ns/1ps
module drdy_burst_reader
  import rdr_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 200_000_000,
  parameter int unsigned MAX_BPS     = 5_000_000,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned CS_GAP      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [RDR_WORD_W-1:0] cfg_word,
  input  logic [ADDR_W-1:0]     buf_len,
  output logic                  busy,
  output logic                  done,
  output logic                  wr_valid,
  input  logic                  wr_ready,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [7:0]            wr_data,
  input  logic                  drdy_n,
  output logic                  cs_n,
  output logic                  sclk,
  output logic                  mosi,
  input  logic                  miso
);
  localparam int unsigned HALF_DIV = (CLK_HZ + 2 * MAX_BPS - 1) / (2 * MAX_BPS);

  logic       drdy_n_s;
  logic       go;
  logic [7:0] tx_byte;
  logic       eng_done;
  logic [7:0] rx_byte;

  rdr_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(drdy_n), .q(drdy_n_s)
  );

  rdr_shift_engine #(.HALF(HALF_DIV), .W(8)) u_eng (
    .clk(clk), .rst_n(rst_n), .go(go), .tx_byte(tx_byte), .miso(miso),
    .sclk(sclk), .mosi(mosi), .byte_done(eng_done), .rx_byte(rx_byte)
  );

  rdr_sequencer #(.ADDR_W(ADDR_W), .GAP(CS_GAP)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_word(cfg_word), .buf_len(buf_len),
    .drdy_ok(!drdy_n_s), .eng_done(eng_done), .rx_byte(rx_byte), .wr_ready(wr_ready),
    .go(go), .tx_byte(tx_byte), .cs_n(cs_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .done(done)
  );
endmodule

// File: rtl/rdr_checker.sv
`timescale 1ns/1ps
module rdr_checker #(
  parameter int unsigned HALF   = 20,
  parameter int unsigned GAP    = 2,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sclk,
  input logic              mosi,
  input logic              done,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data
);
  logic        sclk_q;
  logic [15:0] rise_cnt;
  logic [15:0] stable_cnt;
  logic [15:0] high_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      rise_cnt   <= '0;
      stable_cnt <= 16'hFFFF;
      high_cnt   <= 16'(GAP);
    end else begin
      sclk_q <= sclk;
      if (cs_n)                rise_cnt <= '0;
      else if (sclk && !sclk_q) rise_cnt <= rise_cnt + 1'b1;
      if (sclk != sclk_q)            stable_cnt <= '0;
      else if (stable_cnt != 16'hFFFF) stable_cnt <= stable_cnt + 1'b1;
      if (!cs_n)                   high_cnt <= '0;
      else if (high_cnt != 16'hFFFF) high_cnt <= high_cnt + 1'b1;
    end
  end

  // R8
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);

  // R7
  mosi_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(mosi) |-> !sclk);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr) && $stable(sclk)));

  // R3
  edge_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (rise_cnt == 16'd32));

  // R6
  half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != sclk_q) |-> (stable_cnt >= 16'(HALF - 1)));

  // R8
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (high_cnt >= 16'(GAP)));
endmodule

bind drdy_burst_reader rdr_checker #(.HALF(HALF_DIV), .GAP(CS_GAP), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .done(done),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/drdy_burst_reader_bench.sv
`timescale 1ns/1ps
module drdy_burst_reader_bench;
  localparam int ADDR_W = 8;
  localparam int HALF   = (200_000_000 + 2 * 5_000_000 - 1) / (2 * 5_000_000);
  localparam int GAP    = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [23:0] cfg_word = '0;
  logic [ADDR_W-1:0] buf_len = '0;
  logic busy, done, wr_valid, wr_ready = 1'b1;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0] wr_data;
  logic drdy_n = 1'b1, cs_n, sclk, mosi, miso = 1'b0;

  always #2.5 clk = ~clk;

  drdy_burst_reader u_drdy_burst_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_word(cfg_word), .buf_len(buf_len),
    .busy(busy), .done(done), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .drdy_n(drdy_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  int checks = 0, fails = 0;
  bit reported = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
    $finish;
  endtask

  // Converter model
  logic [31:0] pshift;
  logic [23:0] out_sh;
  logic [23:0] exp_cfg;
  int bitcnt = 0, trans_cnt = 0, cfg_cnt = 0, rd_cnt = 0, sample_n = 0, run_txn = 0;
  bit in_txn = 0, feed_en = 0, stall_en = 0;
  logic [7:0] exp_q[$];

  function automatic logic [23:0] sample_val(input int n);
    case (n)
      0: return 24'hFFFFFF;
      1: return 24'h000000;
      2: return 24'h800001;
      default: return {8'(n * 37), 8'(~n), 8'(n * 5 + 3)};
    endcase
  endfunction

  always @(negedge cs_n) begin
    in_txn = 1;
    bitcnt = 0;
  end

  always @(posedge sclk) if (!cs_n) begin
    pshift = {pshift[30:0], mosi};
    bitcnt++;
    if (bitcnt == 8 && pshift[7:0] == 8'h42) begin
      out_sh = sample_val(sample_n);
      sample_n++;
      exp_q.push_back(out_sh[23:16]);
      exp_q.push_back(out_sh[15:8]);
      exp_q.push_back(out_sh[7:0]);
    end
  end

  always @(negedge sclk) if (!cs_n && bitcnt >= 8) begin
    miso = out_sh[23];
    out_sh = {out_sh[22:0], 1'b0};
  end

  always @(posedge cs_n) if (in_txn) begin
    in_txn = 0;
    trans_cnt++;
    run_txn++;
    chk(bitcnt == 32, "R3", "rising edges per cs window", bitcnt, 32);
    if (run_txn == 1) begin
      chk(pshift[31:24] == 8'hC6, "R1", "config instruction", pshift[31:24], 8'hC6);
      chk(pshift[23:0] == exp_cfg, "R1", "config word", pshift[23:0], exp_cfg);
      cfg_cnt++;
    end else begin
      chk(pshift[31:24] == 8'h42, "R3", "read instruction", pshift[31:24], 8'h42);
      rd_cnt++;
      drdy_n = 1'b1;
    end
  end

  // Data-ready driver
  initial forever begin
    wait (feed_en && drdy_n);
    repeat (30) @(negedge clk);
    if (feed_en) drdy_n = 1'b0;
  end

  // Back-pressure driver
  logic [15:0] lfsr = 16'hACE1;
  initial forever begin
    @(posedge clk);
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    wr_ready = stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // Scoreboard monitor and pin monitor
  int exp_addr = 0, run_bytes = 0, cyc = 0, last_t = 0, min_half = 1 << 30;
  int hi_run = 0, min_gap = 1 << 30, mosi_bad = 0, idle_clk_bad = 0;
  bit have_t = 0, gap_valid = 0;
  logic prev_sclk = 0, prev_cs = 1, prev_mosi = 0;
  logic [7:0] e;

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (wr_valid && wr_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R4", "unexpected write", wr_data, 0);
      end else begin
        e = exp_q.pop_front();
        chk(wr_data == e, "R4/R10", "byte value", wr_data, e);
        chk(wr_addr == ADDR_W'(exp_addr), "R4", "byte address", wr_addr, exp_addr);
      end
      exp_addr++;
      run_bytes++;
    end
    if (cs_n && sclk) idle_clk_bad++;
    if (mosi !== prev_mosi && sclk) mosi_bad++;
    if (!cs_n && sclk !== prev_sclk) begin
      if (have_t && cyc - last_t < min_half) min_half = cyc - last_t;
      last_t = cyc;
      have_t = 1;
    end
    if (cs_n) have_t = 0;
    if (cs_n) hi_run++;
    if (!cs_n && prev_cs) begin
      if (gap_valid && hi_run < min_gap) min_gap = hi_run;
    end
    if (cs_n && !prev_cs) begin
      gap_valid = 1;
      hi_run = 1;
    end
    prev_sclk = sclk;
    prev_cs = cs_n;
    prev_mosi = mosi;
  end

  task automatic pulse_start();
    @(posedge clk);
    #1 start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (done !== 1'b1 && n < 60000) begin
      @(negedge clk);
      n++;
    end
    chk(done === 1'b1, "R5", {tag, " done pulse"}, done, 1);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R5", {tag, " done one cycle, busy low"}, {done, busy}, 0);
  endtask

  initial begin
    int tc;
    repeat (4) @(negedge clk);
    chk(cs_n === 1 && sclk === 0 && busy === 0 && done === 0 && wr_valid === 0, "R11",
        "reset state", {cs_n, sclk, busy, done, wr_valid}, 5'b10000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Run 1: no back-pressure, 6 bytes
    exp_cfg = 24'h5A3C81; cfg_word = exp_cfg; buf_len = 6;
    exp_addr = 0; run_bytes = 0; run_txn = 0; feed_en = 1;
    pulse_start();
    wait_done("run1");
    feed_en = 0;
    chk(run_bytes == 6, "R5", "run1 byte count", run_bytes, 6);
    chk(exp_q.size() == 0, "R4", "run1 queue drained", exp_q.size(), 0);

    // Run 2: data-ready held off, then random back-pressure, start while busy
    repeat (10) @(negedge clk);
    exp_cfg = 24'h13579B; cfg_word = exp_cfg; buf_len = 7;
    exp_addr = 0; run_bytes = 0; run_txn = 0; stall_en = 1;
    pulse_start();
    wait (cfg_cnt == 2);
    tc = trans_cnt;
    repeat (400) @(negedge clk);
    chk(trans_cnt == tc && cs_n === 1'b1, "R2", "no access while drdy_n high",
        trans_cnt, tc);
    feed_en = 1;
    wait (rd_cnt == 3);
    cfg_word = 24'hFFFFFF; buf_len = 1;
    pulse_start();
    wait_done("run2");
    feed_en = 0;
    stall_en = 0;
    chk(run_bytes == 9, "R9", "run2 byte count unchanged by start", run_bytes, 9);
    chk(cfg_cnt == 2, "R9", "single config per run", cfg_cnt, 2);
    chk(exp_q.size() == 0, "R10", "no byte lost under stall", exp_q.size(), 0);
    chk(min_half >= HALF, "R6", "shortest sclk phase", min_half, HALF);
    chk(mosi_bad == 0, "R7", "mosi changes with sclk high", mosi_bad, 0);
    chk(idle_clk_bad == 0, "R8", "sclk high while cs high", idle_clk_bad, 0);
    chk(min_gap >= GAP, "R8", "shortest cs high gap", min_gap, GAP);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule